// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block takes fault requests from a 32-bit processor pipeline and performs exception entry in a single clock edge. It records the exception code, the branch-delay flag and the coprocessor number in the cause register. It saves the return address, sets the exception-level bit in the status register, and captures the faulting address and the translation context when the fault type calls for them. It also hands the fetch unit a redirect target: the PC plus the two sequential PCs that follow it.

A separate reset request steers fetch to the reset vector and enables the floating-point coprocessor. When several requests arrive in the same cycle, only the highest-priority one takes effect.

A small register port reads all six control registers and writes the handler base, status and cause registers. The fetch unit sees the redirect one cycle after the request, through registered outputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Priority is fixed. `rst_fault_i` beats every bit of `fault_req_i`. Among the bits of `fault_req_i`, the lowest set index wins. Only the winning request changes any register.
- R2: The `fault_req_i` bit index selects the fault kind, and each kind writes its own code into cause[6:2]. 0 load address error→4, 1 store address error→5, 2 write to read-only page→1, 3 load/fetch TLB refill→2, 4 store TLB refill→3, 5 load/fetch TLB invalid→2, 6 store TLB invalid→3, 7 system call→8, 8 breakpoint→9, 9 reserved instruction→0xA, 10 coprocessor unusable→0xB, 11 arithmetic overflow→0xC, 12 trap→0xD, 13 interrupt→0.
- R3: Every fault copies `fault_bd_i` into cause[31]. Every fault clears cause[29:28], except a coprocessor-unusable fault, which loads `fault_cop_i` into cause[29:28]. All other cause bits are kept.
- R4: On a fault, the saved return address is `fault_pc_i`, or `fault_pc_i`−4 when `fault_bd_i` is 1. Status bit 1 (exception level) is set.
- R5: Unless R6 to R8 apply, the handler address is EBASE+0x180.
- R6: An arithmetic fault goes to 0xBFC00200 when status bit 22 (boot vectors) is 1, and to EBASE+0x180 when it is 0.
- R7: A TLB refill fault (index 3 or 4) goes to EBASE with no offset when status bit 22 is 0, and to EBASE+0x180 when it is 1.
- R8: An interrupt goes to EBASE+0x200 when cause bit 23 is 1, and to EBASE+0x180 when it is 0.
- R9: Address-error and TLB faults (indices 0 to 6) load `fault_vaddr_i` into the bad-address register. Other faults leave it unchanged.
- R10: TLB faults (indices 2 to 6) write the translation-context register fields: VPN2 into bits [31:13], the VPN2 extension into [12:11], and the ASID into [7:0]. Bits [10:8] keep their value. Other faults leave this register unchanged.
- R11: A reset request drives the redirect to 0xBFC00000, 0xBFC00004 and 0xBFC00008, and sets status bit 29 (floating-point coprocessor usable). It changes no other register.
- R12: Register port addresses are 0 EBASE, 1 status, 2 cause, 3 return address, 4 bad address, 5 translation context. Reads are combinational. Only addresses 0 to 2 are writable. A write in a cycle that carries any request is dropped. Reset values are EBASE 0x80000000, status 0x00400000, and 0 for the rest.
- R13: `redirect_valid_o` is high for exactly the cycle after a request, with the handler in `redirect_pc_o` and the handler plus 4 and plus 8 in the next-PC outputs. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_fault_i | input | 1 | Reset exception request |
| fault_req_i | input | 14 | One request bit per fault kind |
| fault_vaddr_i | input | 32 | Faulting virtual address |
| fault_pc_i | input | 32 | PC of the faulting instruction |
| fault_bd_i | input | 1 | Faulting instruction sits in a branch-delay slot |
| fault_asid_i | input | 8 | ASID of the faulting access |
| fault_vpn2_i | input | 19 | VPN2 of the faulting access |
| fault_vpn2x_i | input | 2 | VPN2 extension of the faulting access |
| fault_cop_i | input | 2 | Coprocessor number for an unusable-coprocessor fault |
| csr_wr_en_i | input | 1 | Register port write strobe |
| csr_addr_i | input | 3 | Register port address |
| csr_wdata_i | input | 32 | Register port write data |
| csr_rdata_o | output | 32 | Register port read data |
| redirect_valid_o | output | 1 | Redirect target is valid |
| redirect_pc_o | output | 32 | New fetch PC |
| redirect_npc_o | output | 32 | New fetch PC + 4 |
| redirect_nnpc_o | output | 32 | New fetch PC + 8 |

## Verification
The main function is exercised with one request of each handler class:
- a general fault, which fixes the base offset;
- the arithmetic fault under both boot-vector settings;
- the refill fault under both boot-vector settings, which separates the no-offset case;
- the interrupt under both cause-vector settings.

A branch-delay fault and an ordinary fault show the return-address adjustment and the BD copy. Faults inside and outside the address and TLB groups show which registers are captured and which are left alone.

Combined request vectors, and a reset request paired with a fault, show that only the winner updates state. A register write paired with a fault shows that the write is dropped.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NUM_FAULT = 14;
    localparam int FIDX_W    = 4;
    localparam int EXC_W     = 5;

    // fault kinds, position in the request vector is also the priority
    localparam logic [FIDX_W-1:0] F_ADDR_LD  = 4'd0;
    localparam logic [FIDX_W-1:0] F_ADDR_ST  = 4'd1;
    localparam logic [FIDX_W-1:0] F_TLB_RO   = 4'd2;
    localparam logic [FIDX_W-1:0] F_RFL_LD   = 4'd3;
    localparam logic [FIDX_W-1:0] F_RFL_ST   = 4'd4;
    localparam logic [FIDX_W-1:0] F_INV_LD   = 4'd5;
    localparam logic [FIDX_W-1:0] F_INV_ST   = 4'd6;
    localparam logic [FIDX_W-1:0] F_SYSCALL  = 4'd7;
    localparam logic [FIDX_W-1:0] F_BREAK    = 4'd8;
    localparam logic [FIDX_W-1:0] F_RSVD     = 4'd9;
    localparam logic [FIDX_W-1:0] F_COP      = 4'd10;
    localparam logic [FIDX_W-1:0] F_OVF      = 4'd11;
    localparam logic [FIDX_W-1:0] F_TRAP     = 4'd12;
    localparam logic [FIDX_W-1:0] F_INTR     = 4'd13;

    // control register field positions
    localparam int ST_EXL   = 1;
    localparam int ST_BEV   = 22;
    localparam int ST_CU1   = 29;
    localparam int CA_CODE_LO = 2;
    localparam int CA_CODE_HI = 6;
    localparam int CA_IV    = 23;
    localparam int CA_CE_LO = 28;
    localparam int CA_CE_HI = 29;
    localparam int CA_BD    = 31;
    localparam int EH_ASID_LO = 0;
    localparam int EH_VX_LO   = 11;
    localparam int EH_VPN_LO  = 13;

    // register port addresses
    localparam logic [2:0] A_EBASE  = 3'd0;
    localparam logic [2:0] A_STATUS = 3'd1;
    localparam logic [2:0] A_CAUSE  = 3'd2;
    localparam logic [2:0] A_EPC    = 3'd3;
    localparam logic [2:0] A_BADVA  = 3'd4;
    localparam logic [2:0] A_ENTHI  = 3'd5;

    function automatic logic [EXC_W-1:0] code_of(input logic [FIDX_W-1:0] k);
        logic [EXC_W-1:0] c;
        case (k)
            F_ADDR_LD: c = 5'h04;
            F_ADDR_ST: c = 5'h05;
            F_TLB_RO:  c = 5'h01;
            F_RFL_LD,
            F_INV_LD:  c = 5'h02;
            F_RFL_ST,
            F_INV_ST:  c = 5'h03;
            F_SYSCALL: c = 5'h08;
            F_BREAK:   c = 5'h09;
            F_RSVD:    c = 5'h0A;
            F_COP:     c = 5'h0B;
            F_OVF:     c = 5'h0C;
            F_TRAP:    c = 5'h0D;
            default:   c = 5'h00;
        endcase
        return c;
    endfunction

    function automatic logic is_tlb(input logic [FIDX_W-1:0] k);
        return (k >= F_TLB_RO) && (k <= F_INV_ST);
    endfunction

    function automatic logic takes_vaddr(input logic [FIDX_W-1:0] k);
        return k <= F_INV_ST;
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int N = NUM_FAULT
) (
    input  logic [N-1:0]      req_i,
    output logic              any_o,
    output logic [FIDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = FIDX_W'(i);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0180,
    parameter logic [XLEN-1:0] INT_OFS   = 32'h0000_0200,
    parameter logic [XLEN-1:0] BOOT_ARITH = 32'hBFC0_0200
) (
    input  logic [FIDX_W-1:0] kind_i,
    input  logic [XLEN-1:0]   ebase_i,
    input  logic              bev_i,
    input  logic              iv_i,
    output logic [XLEN-1:0]   handler_o
);

    logic [XLEN-1:0] gen_addr;
    logic [XLEN-1:0] int_addr;

    assign gen_addr = ebase_i + GEN_OFS;
    assign int_addr = ebase_i + INT_OFS;

    always_comb begin
        handler_o = gen_addr;
        if (kind_i == F_OVF) begin
            handler_o = bev_i ? BOOT_ARITH : gen_addr;
        end else if (kind_i == F_RFL_LD || kind_i == F_RFL_ST) begin
            handler_o = bev_i ? gen_addr : ebase_i;
        end else if (kind_i == F_INTR) begin
            handler_o = iv_i ? int_addr : gen_addr;
        end
    end

endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              ASID_W    = 8,
    parameter int              VPN2_W    = 19,
    parameter int              VPN2X_W   = 2,
    parameter int              COP_W     = 2,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] EBASE_RST = 32'h8000_0000,
    parameter logic [XLEN-1:0] STAT_RST  = 32'h0040_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_fault_i,
    input  logic               fault_valid_i,
    input  logic [FIDX_W-1:0]  fault_idx_i,
    input  logic [XLEN-1:0]    handler_i,
    input  logic [XLEN-1:0]    fault_vaddr_i,
    input  logic [XLEN-1:0]    fault_pc_i,
    input  logic               fault_bd_i,
    input  logic [ASID_W-1:0]  fault_asid_i,
    input  logic [VPN2_W-1:0]  fault_vpn2_i,
    input  logic [VPN2X_W-1:0] fault_vpn2x_i,
    input  logic [COP_W-1:0]   fault_cop_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_addr_i,
    input  logic [XLEN-1:0]    wr_data_i,
    output logic [XLEN-1:0]    ebase_o,
    output logic [XLEN-1:0]    status_o,
    output logic [XLEN-1:0]    cause_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    badva_o,
    output logic [XLEN-1:0]    enthi_o,
    output logic               redir_v_o,
    output logic [XLEN-1:0]    redir_pc_o,
    output logic [XLEN-1:0]    redir_npc_o,
    output logic [XLEN-1:0]    redir_nnpc_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    typedef struct packed {
        logic [XLEN-1:0] ebase;
        logic [XLEN-1:0] status;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] badva;
        logic [XLEN-1:0] enthi;
        logic            redir_v;
        logic [XLEN-1:0] redir_pc;
        logic [XLEN-1:0] redir_npc;
        logic [XLEN-1:0] redir_nnpc;
    } state_t;

    state_t s_d, s_q;
    logic   take_fault;

    assign take_fault = fault_valid_i && !rst_fault_i;

    always_comb begin
        s_d         = s_q;
        s_d.redir_v = 1'b0;
        if (rst_fault_i) begin
            s_d.redir_v          = 1'b1;
            s_d.redir_pc         = RESET_VEC;
            s_d.redir_npc        = RESET_VEC + STEP;
            s_d.redir_nnpc       = RESET_VEC + STEP + STEP;
            s_d.status[ST_CU1]   = 1'b1;
        end else if (fault_valid_i) begin
            s_d.cause[CA_CODE_HI:CA_CODE_LO] = code_of(fault_idx_i);
            s_d.cause[CA_BD]                 = fault_bd_i;
            s_d.cause[CA_CE_HI:CA_CE_LO]     = (fault_idx_i == F_COP) ? fault_cop_i : '0;
            s_d.epc                          = fault_bd_i ? (fault_pc_i - STEP) : fault_pc_i;
            s_d.status[ST_EXL]               = 1'b1;
            if (takes_vaddr(fault_idx_i)) begin
                s_d.badva = fault_vaddr_i;
            end
            if (is_tlb(fault_idx_i)) begin
                s_d.enthi[EH_ASID_LO +: ASID_W]  = fault_asid_i;
                s_d.enthi[EH_VX_LO   +: VPN2X_W] = fault_vpn2x_i;
                s_d.enthi[EH_VPN_LO  +: VPN2_W]  = fault_vpn2_i;
            end
            s_d.redir_v    = 1'b1;
            s_d.redir_pc   = handler_i;
            s_d.redir_npc  = handler_i + STEP;
            s_d.redir_nnpc = handler_i + STEP + STEP;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                A_EBASE:  s_d.ebase  = wr_data_i;
                A_STATUS: s_d.status = wr_data_i;
                A_CAUSE:  s_d.cause  = wr_data_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.ebase  <= EBASE_RST;
            s_q.status <= STAT_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign ebase_o      = s_q.ebase;
    assign status_o     = s_q.status;
    assign cause_o      = s_q.cause;
    assign epc_o        = s_q.epc;
    assign badva_o      = s_q.badva;
    assign enthi_o      = s_q.enthi;
    assign redir_v_o    = s_q.redir_v;
    assign redir_pc_o   = s_q.redir_pc;
    assign redir_npc_o  = s_q.redir_npc;
    assign redir_nnpc_o = s_q.redir_nnpc;

    // R13
    redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_fault_i || fault_valid_i) |=> redir_v_o);

    // R13
    redir_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_fault_i || fault_valid_i) |=> !redir_v_o);

    // R4
    exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_fault |=> status_o[ST_EXL]);

    // R4
    epc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_fault |=> epc_o == ($past(fault_bd_i) ? $past(fault_pc_i) - STEP : $past(fault_pc_i)));

    // R11
    reset_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fault_i |=> status_o[ST_CU1] && redir_pc_o == RESET_VEC && $stable(cause_o));

    // R9
    badva_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_fault && !takes_vaddr(fault_idx_i)) |=> $stable(badva_o));

    // R12
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (fault_valid_i || rst_fault_i)) |=> $stable(ebase_o));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              NFAULT     = NUM_FAULT,
    parameter int              ASID_W     = 8,
    parameter int              VPN2_W     = 19,
    parameter int              VPN2X_W    = 2,
    parameter int              COP_W      = 2,
    parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BOOT_ARITH = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] GEN_OFS    = 32'h0000_0180,
    parameter logic [XLEN-1:0] INT_OFS    = 32'h0000_0200,
    parameter logic [XLEN-1:0] EBASE_RST  = 32'h8000_0000,
    parameter logic [XLEN-1:0] STAT_RST   = 32'h0040_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_fault_i,
    input  logic [NFAULT-1:0]  fault_req_i,
    input  logic [XLEN-1:0]    fault_vaddr_i,
    input  logic [XLEN-1:0]    fault_pc_i,
    input  logic               fault_bd_i,
    input  logic [ASID_W-1:0]  fault_asid_i,
    input  logic [VPN2_W-1:0]  fault_vpn2_i,
    input  logic [VPN2X_W-1:0] fault_vpn2x_i,
    input  logic [COP_W-1:0]   fault_cop_i,
    input  logic               csr_wr_en_i,
    input  logic [2:0]         csr_addr_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    output logic               redirect_valid_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic [XLEN-1:0]    redirect_npc_o,
    output logic [XLEN-1:0]    redirect_nnpc_o
);

    logic              any_req;
    logic [FIDX_W-1:0] win_idx;
    logic [XLEN-1:0]   handler;
    logic [XLEN-1:0]   ebase_q, status_q, cause_q, epc_q, badva_q, enthi_q;

    exc_prio #(.N(NFAULT)) u_prio (
        .req_i (fault_req_i),
        .any_o (any_req),
        .idx_o (win_idx)
    );

    exc_vector #(
        .XLEN       (XLEN),
        .GEN_OFS    (GEN_OFS),
        .INT_OFS    (INT_OFS),
        .BOOT_ARITH (BOOT_ARITH)
    ) u_vec (
        .kind_i    (win_idx),
        .ebase_i   (ebase_q),
        .bev_i     (status_q[ST_BEV]),
        .iv_i      (cause_q[CA_IV]),
        .handler_o (handler)
    );

    exc_state #(
        .XLEN      (XLEN),
        .ASID_W    (ASID_W),
        .VPN2_W    (VPN2_W),
        .VPN2X_W   (VPN2X_W),
        .COP_W     (COP_W),
        .RESET_VEC (RESET_VEC),
        .EBASE_RST (EBASE_RST),
        .STAT_RST  (STAT_RST)
    ) u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .rst_fault_i   (rst_fault_i),
        .fault_valid_i (any_req),
        .fault_idx_i   (win_idx),
        .handler_i     (handler),
        .fault_vaddr_i (fault_vaddr_i),
        .fault_pc_i    (fault_pc_i),
        .fault_bd_i    (fault_bd_i),
        .fault_asid_i  (fault_asid_i),
        .fault_vpn2_i  (fault_vpn2_i),
        .fault_vpn2x_i (fault_vpn2x_i),
        .fault_cop_i   (fault_cop_i),
        .wr_en_i       (csr_wr_en_i),
        .wr_addr_i     (csr_addr_i),
        .wr_data_i     (csr_wdata_i),
        .ebase_o       (ebase_q),
        .status_o      (status_q),
        .cause_o       (cause_q),
        .epc_o         (epc_q),
        .badva_o       (badva_q),
        .enthi_o       (enthi_q),
        .redir_v_o     (redirect_valid_o),
        .redir_pc_o    (redirect_pc_o),
        .redir_npc_o   (redirect_npc_o),
        .redir_nnpc_o  (redirect_nnpc_o)
    );

    always_comb begin
        case (csr_addr_i)
            A_EBASE:  csr_rdata_o = ebase_q;
            A_STATUS: csr_rdata_o = status_q;
            A_CAUSE:  csr_rdata_o = cause_q;
            A_EPC:    csr_rdata_o = epc_q;
            A_BADVA:  csr_rdata_o = badva_q;
            A_ENTHI:  csr_rdata_o = enthi_q;
            default:  csr_rdata_o = '0;
        endcase
    end

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_fault = 1'b0;
    logic [13:0] fault_req = '0;
    logic [31:0] vaddr = '0, pc = '0;
    logic        bd = 1'b0;
    logic [7:0]  asid = '0;
    logic [18:0] vpn2 = '0;
    logic [1:0]  vpn2x = '0, cop = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        rv;
    logic [31:0] rpc, rnpc, rnnpc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rst_fault_i(rst_fault), .fault_req_i(fault_req),
        .fault_vaddr_i(vaddr), .fault_pc_i(pc), .fault_bd_i(bd), .fault_asid_i(asid),
        .fault_vpn2_i(vpn2), .fault_vpn2x_i(vpn2x), .fault_cop_i(cop),
        .csr_wr_en_i(wr_en), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
        .redirect_valid_o(rv), .redirect_pc_o(rpc), .redirect_npc_o(rnpc),
        .redirect_nnpc_o(rnnpc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive one request cycle; on return the results are visible
    task automatic fire(input logic [13:0] r, input logic rf);
        @(negedge clk);
        fault_req = r; rst_fault = rf;
        @(negedge clk);
        fault_req = '0; rst_fault = 1'b0;
    endtask

    task automatic chk_redir(input string req, input logic [31:0] h);
        chk(req, "valid", {31'b0, rv}, 32'd1);
        chk(req, "pc", rpc, h);
        chk(req, "npc", rnpc, h + 32'd4);
        chk(req, "nnpc", rnnpc, h + 32'd8);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(3'd0, v); chk("R12", "ebase rst", v, 32'h8000_0000);
        rd(3'd1, v); chk("R12", "status rst", v, 32'h0040_0000);
        rd(3'd2, v); chk("R12", "cause rst", v, 32'h0);
        chk("R13", "valid rst", {31'b0, rv}, 32'd0);
    endtask

    task automatic t_port();
        logic [31:0] v;
        csr_wr(3'd1, 32'h0);
        csr_wr(3'd0, 32'h8000_1000);
        csr_wr(3'd3, 32'h1234_5678);
        rd(3'd0, v); chk("R12", "ebase wr", v, 32'h8000_1000);
        rd(3'd1, v); chk("R12", "status wr", v, 32'h0);
        rd(3'd3, v); chk("R12", "epc not writable", v, 32'h0);
    endtask

    task automatic t_general();
        logic [31:0] v;
        pc = 32'h0000_1000; bd = 1'b0; vaddr = 32'hDEAD_0000;
        fire(14'h1 << 7, 1'b0);
        chk_redir("R5", 32'h8000_1180);
        rd(3'd2, v); chk("R2", "syscall code", {27'b0, v[6:2]}, 32'h8);
        rd(3'd3, v); chk("R4", "epc", v, 32'h1000);
        rd(3'd1, v); chk("R4", "exl", {31'b0, v[1]}, 32'd1);
        rd(3'd4, v); chk("R9", "badva kept", v, 32'h0);
    endtask

    task automatic t_bd();
        logic [31:0] v;
        pc = 32'h0000_2004; bd = 1'b1;
        fire(14'h1 << 8, 1'b0);
        rd(3'd3, v); chk("R4", "epc bd", v, 32'h2000);
        rd(3'd2, v);
        chk("R3", "bd bit", {31'b0, v[31]}, 32'd1);
        chk("R2", "break code", {27'b0, v[6:2]}, 32'h9);
        bd = 1'b0;
    endtask

    task automatic t_cop();
        logic [31:0] v;
        cop = 2'd2;
        fire(14'h1 << 10, 1'b0);
        rd(3'd2, v);
        chk("R3", "ce loaded", {30'b0, v[29:28]}, 32'd2);
        chk("R2", "cop code", {27'b0, v[6:2]}, 32'hB);
        chk("R3", "bd cleared", {31'b0, v[31]}, 32'd0);
        fire(14'h1 << 12, 1'b0);
        rd(3'd2, v);
        chk("R3", "ce cleared", {30'b0, v[29:28]}, 32'd0);
        chk("R2", "trap code", {27'b0, v[6:2]}, 32'hD);
    endtask

    task automatic t_addr_err();
        logic [31:0] v;
        vaddr = 32'h0000_0ABD;
        fire(14'h1 << 1, 1'b0);
        chk_redir("R5", 32'h8000_1180);
        rd(3'd4, v); chk("R9", "badva store err", v, 32'h0000_0ABD);
        rd(3'd5, v); chk("R10", "enthi kept", v, 32'h0);
        rd(3'd2, v); chk("R2", "adesc code", {27'b0, v[6:2]}, 32'h5);
    endtask

    task automatic t_tlb_inv();
        logic [31:0] v;
        vaddr = 32'h2468_A000; asid = 8'h5A; vpn2 = 19'h12345; vpn2x = 2'd2;
        fire(14'h1 << 5, 1'b0);
        chk_redir("R5", 32'h8000_1180);
        rd(3'd5, v); chk("R10", "enthi", v, (32'h12345 << 13) | (32'd2 << 11) | 32'h5A);
        rd(3'd4, v); chk("R9", "badva tlb", v, 32'h2468_A000);
        rd(3'd2, v); chk("R2", "inv load code", {27'b0, v[6:2]}, 32'h2);
    endtask

    task automatic t_refill();
        logic [31:0] v;
        fire(14'h1 << 4, 1'b0);
        chk_redir("R7", 32'h8000_1000);
        rd(3'd2, v); chk("R2", "refill store code", {27'b0, v[6:2]}, 32'h3);
        csr_wr(3'd1, 32'h0040_0000);
        fire(14'h1 << 3, 1'b0);
        chk_redir("R7", 32'h8000_1180);
    endtask

    task automatic t_arith();
        csr_wr(3'd1, 32'h0040_0000);
        fire(14'h1 << 11, 1'b0);
        chk_redir("R6", 32'hBFC0_0200);
        csr_wr(3'd1, 32'h0);
        fire(14'h1 << 11, 1'b0);
        chk_redir("R6", 32'h8000_1180);
    endtask

    task automatic t_intr();
        logic [31:0] v;
        csr_wr(3'd2, 32'h0080_0000);
        fire(14'h1 << 13, 1'b0);
        chk_redir("R8", 32'h8000_1200);
        rd(3'd2, v);
        chk("R8", "iv kept", {31'b0, v[23]}, 32'd1);
        chk("R2", "int code", {27'b0, v[6:2]}, 32'h0);
        csr_wr(3'd2, 32'h0);
        fire(14'h1 << 13, 1'b0);
        chk_redir("R8", 32'h8000_1180);
    endtask

    task automatic t_prio();
        logic [31:0] v, epc0, cause0;
        fire((14'h1 << 12) | (14'h1 << 7) | (14'h1 << 3), 1'b0);
        rd(3'd2, v); chk("R1", "lowest wins", {27'b0, v[6:2]}, 32'h2);
        chk_redir("R1", 32'h8000_1000);
        rd(3'd3, epc0); rd(3'd2, cause0);
        pc = 32'h0000_7000;
        fire(14'h1 << 7, 1'b1);
        chk_redir("R11", 32'hBFC0_0000);
        rd(3'd3, v); chk("R1", "epc untouched", v, epc0);
        rd(3'd2, v); chk("R1", "cause untouched", v, cause0);
        rd(3'd1, v); chk("R11", "cu1", {31'b0, v[29]}, 32'd1);
    endtask

    task automatic t_wr_drop();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = 32'h9000_0000; fault_req = 14'h1 << 7;
        @(negedge clk);
        wr_en = 1'b0; fault_req = '0;
        rd(3'd0, v); chk("R12", "write dropped", v, 32'h8000_1000);
        @(negedge clk);
        chk("R13", "valid idle", {31'b0, rv}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_port();
        t_general();
        t_bd();
        t_cop();
        t_addr_err();
        t_tlb_inv();
        t_refill();
        t_arith();
        t_intr();
        t_prio();
        t_wr_drop();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule